// File: doc/BRIEF.md
# Processor-to-Local-Bus Master Bridge

This block lets a processor on the system-side bus run single read and write cycles on a slower local peripheral bus, with the bridge as the local bus master. The local bus runs at half the processor clock rate. The bridge generates that local clock from a phase register that toggles every processor cycle. Every local-bus action is launched or sampled only on a local rising edge.

A one-cycle request pulse from the processor is accepted when the bridge is idle. The bridge latches the address, the direction and the write data, then waits for the next local rising edge. From that edge it holds the active-low address strobe for two local cycles and, on writes, drives the data bus. After the strobe it polls the active-low local ready on each local rising edge. In the processor cycle right after it sees ready low, it pulses the processor-side ready and the 32-bit sizing indication together for one cycle. On a read, the data captured at the ready edge is presented on the processor read-data output at the same time. Only one transaction is in flight at a time.

Top module: `lb_bridge`

## Requirements
- R1: After reset, cpu_rdy_n, cpu_size32_n and lb_ads_n are 1, lb_wdata_oe is 0 and lb_clk is 0.
- R2: lb_clk toggles on every processor clock edge, so the local clock runs at half the processor rate. A local rising edge is a processor edge at which lb_clk goes from 0 to 1.
- R3: lb_ads_n falls only at a local rising edge, so lb_clk is 1 in the first cycle the strobe is low. This holds whatever the phase of the accepted request.
- R4: lb_ads_n stays low for exactly two local cycles, which is four processor cycles, once per transaction.
- R5: On a write (cpu_we=1), lb_wr is 1 and lb_wdata_oe rises together with the strobe. lb_wdata_oe stays high until the ready edge, with lb_wdata equal to the latched write data. On a read, lb_wdata_oe stays 0 and lb_wr is 0.
- R6: lb_rdy_n is sampled only at local rising edges after the strobe has ended. cpu_rdy_n is low in the processor cycle right after the edge that sees it low. Each extra local wait cycle therefore adds two processor cycles.
- R7: On a read, cpu_rdata holds the lb_rdata value present at the ready-sampling edge while cpu_rdy_n is low.
- R8: cpu_size32_n is low in exactly the same cycle as cpu_rdy_n, and both are low for one processor cycle only.
- R9: lb_addr and lb_wr are latched when the request is accepted. They stay stable until ready is returned, even if cpu_addr and cpu_we change meanwhile.
- R10: A cpu_req pulse while a transaction is in flight is ignored: it starts no further strobe and does not change lb_addr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request pulse from the processor, accepted when idle |
| cpu_we | input | 1 | Direction of the request: 1 write, 0 read |
| cpu_addr | input | ADDR_W | Request address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data returned to the processor |
| cpu_rdy_n | output | 1 | Active-low processor-side data ready |
| cpu_size32_n | output | 1 | Active-low 32-bit bus-sizing indication |
| lb_clk | output | 1 | Local bus clock at half the processor rate |
| lb_ads_n | output | 1 | Active-low local address strobe |
| lb_wr | output | 1 | Local direction: 1 write, 0 read |
| lb_addr | output | ADDR_W | Local address |
| lb_wdata | output | DATA_W | Local write data |
| lb_wdata_oe | output | 1 | Enable for driving lb_wdata onto the local bus |
| lb_rdata | input | DATA_W | Local read data from the slave |
| lb_rdy_n | input | 1 | Active-low local ready from the slave |

## Verification
The bench issues requests in both clock phases, so a bridge that starts the strobe on a falling local edge shows a strobe beginning with lb_clk low. A local slave with a programmable wait count of zero, one, two or three cycles checks the distance from strobe end to processor ready. Ready sampled on the wrong edge, or one cycle late, shifts that distance. The slave drives junk read data outside its ready cycle, so data captured a cycle early or late returns the wrong word. Requests injected mid-transaction with a changed address expose a bridge that re-accepts while busy: it would run a second strobe or move lb_addr.

// File: rtl/lb_bridge_pkg.sv
package lb_bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALIGN,
        ST_STROBE,
        ST_WAIT,
        ST_DONE
    } lb_state_e;

    localparam int unsigned STROBE_LCYC = 2;

endpackage

// File: rtl/lb_phase_gen.sv
module lb_phase_gen (
    input  logic clk,
    input  logic rst_n,
    output logic lb_clk_o,
    output logic lrise_o
);

    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign lb_clk_o = phase_q;
    // the coming edge raises the local clock when it is currently low
    assign lrise_o  = ~phase_q;

endmodule

// File: rtl/lb_seq_fsm.sv
module lb_seq_fsm
    import lb_bridge_pkg::*;
#(
    parameter int unsigned STROBE_CYC = STROBE_LCYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic we_i,
    input  logic lrise_i,
    input  logic lb_rdy_n_i,
    output logic accept_o,
    output logic capture_o,
    output logic ads_n_o,
    output logic oe_o,
    output logic rdy_n_o,
    output logic size_n_o
);

    localparam int unsigned CW = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(STROBE_CYC - 1);

    typedef struct packed {
        lb_state_e     state;
        logic [CW-1:0] cnt;
        logic          ads_n;
        logic          oe;
        logic          rdy_n;
        logic          size_n;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        accept_o  = 1'b0;
        capture_o = 1'b0;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (req_i) begin
                    accept_o    = 1'b1;
                    seq_d.state = ST_ALIGN;
                end
            end
            ST_ALIGN: begin
                if (lrise_i) begin
                    seq_d.ads_n = 1'b0;
                    seq_d.oe    = we_i;
                    seq_d.cnt   = '0;
                    seq_d.state = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (lrise_i) begin
                    if (seq_q.cnt == CNT_LAST) begin
                        seq_d.ads_n = 1'b1;
                        seq_d.state = ST_WAIT;
                    end else begin
                        seq_d.cnt = seq_q.cnt + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (lrise_i && !lb_rdy_n_i) begin
                    capture_o    = 1'b1;
                    seq_d.oe     = 1'b0;
                    seq_d.rdy_n  = 1'b0;
                    seq_d.size_n = 1'b0;
                    seq_d.state  = ST_DONE;
                end
            end
            ST_DONE: begin
                seq_d.rdy_n  = 1'b1;
                seq_d.size_n = 1'b1;
                seq_d.state  = ST_IDLE;
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.state  <= ST_IDLE;
            seq_q.cnt    <= '0;
            seq_q.ads_n  <= 1'b1;
            seq_q.oe     <= 1'b0;
            seq_q.rdy_n  <= 1'b1;
            seq_q.size_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ads_n_o  = seq_q.ads_n;
    assign oe_o     = seq_q.oe;
    assign rdy_n_o  = seq_q.rdy_n;
    assign size_n_o = seq_q.size_n;

endmodule

// File: rtl/lb_data_path.sv
module lb_data_path #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              capture_i,
    input  logic              cpu_we_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    input  logic [DATA_W-1:0] lb_rdata_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t dp_d, dp_q;

    always_comb begin
        dp_d = dp_q;
        if (accept_i) begin
            dp_d.we    = cpu_we_i;
            dp_d.addr  = cpu_addr_i;
            dp_d.wdata = cpu_wdata_i;
        end
        if (capture_i && !dp_q.we) begin
            dp_d.rdata = lb_rdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign we_o    = dp_q.we;
    assign addr_o  = dp_q.addr;
    assign wdata_o = dp_q.wdata;
    assign rdata_o = dp_q.rdata;

endmodule

// File: rtl/lb_bridge.sv
module lb_bridge
    import lb_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned STROBE_CYC = STROBE_LCYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_rdy_n,
    output logic              cpu_size32_n,
    output logic              lb_clk,
    output logic              lb_ads_n,
    output logic              lb_wr,
    output logic [ADDR_W-1:0] lb_addr,
    output logic [DATA_W-1:0] lb_wdata,
    output logic              lb_wdata_oe,
    input  logic [DATA_W-1:0] lb_rdata,
    input  logic              lb_rdy_n
);

    logic lrise;
    logic accept;
    logic capture;
    logic we_lat;

    lb_phase_gen u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .lb_clk_o (lb_clk),
        .lrise_o  (lrise)
    );

    lb_seq_fsm #(
        .STROBE_CYC (STROBE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (cpu_req),
        .we_i       (we_lat),
        .lrise_i    (lrise),
        .lb_rdy_n_i (lb_rdy_n),
        .accept_o   (accept),
        .capture_o  (capture),
        .ads_n_o    (lb_ads_n),
        .oe_o       (lb_wdata_oe),
        .rdy_n_o    (cpu_rdy_n),
        .size_n_o   (cpu_size32_n)
    );

    lb_data_path #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .capture_i   (capture),
        .cpu_we_i    (cpu_we),
        .cpu_addr_i  (cpu_addr),
        .cpu_wdata_i (cpu_wdata),
        .lb_rdata_i  (lb_rdata),
        .we_o        (we_lat),
        .addr_o      (lb_addr),
        .wdata_o     (lb_wdata),
        .rdata_o     (cpu_rdata)
    );

    assign lb_wr = we_lat;

endmodule

// File: rtl/lb_bridge_chk.sv
module lb_bridge_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lb_clk,
    input logic              lb_ads_n,
    input logic              lb_wdata_oe,
    input logic              lb_wr,
    input logic [ADDR_W-1:0] lb_addr,
    input logic              lb_rdy_n,
    input logic              cpu_rdy_n,
    input logic              cpu_size32_n
);

    a_r3_ads_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lb_ads_n) |-> lb_clk);

    a_r4_ads_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lb_ads_n) |-> (!$past(lb_ads_n, 4) && $past(lb_ads_n, 5)));

    a_r5_oe_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lb_wdata_oe) |-> (lb_clk && !lb_ads_n && lb_wr));

    a_r6_rdy_after_local: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_rdy_n) |-> ($past(lb_rdy_n) == 1'b0 && $past(lb_clk) == 1'b0));

    a_r8_size_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy_n == cpu_size32_n);

    a_r8_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdy_n |=> cpu_rdy_n);

    a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!lb_ads_n && !$past(lb_ads_n)) |-> ($stable(lb_addr) && $stable(lb_wr)));

endmodule

bind lb_bridge lb_bridge_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lb_clk       (lb_clk),
    .lb_ads_n     (lb_ads_n),
    .lb_wdata_oe  (lb_wdata_oe),
    .lb_wr        (lb_wr),
    .lb_addr      (lb_addr),
    .lb_rdy_n     (lb_rdy_n),
    .cpu_rdy_n    (cpu_rdy_n),
    .cpu_size32_n (cpu_size32_n)
);

// File: tb/lb_bridge_tb.sv
module lb_bridge_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_rdy_n;
    logic          cpu_size32_n;
    logic          lb_clk;
    logic          lb_ads_n;
    logic          lb_wr;
    logic [AW-1:0] lb_addr;
    logic [DW-1:0] lb_wdata;
    logic          lb_wdata_oe;
    logic [DW-1:0] lb_rdata = 32'hDEAD_BEEF;
    logic          lb_rdy_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // local slave model
    int            slv_waits = 0;
    logic [DW-1:0] slv_data = '0;
    bit            slv_active = 0;
    int            slv_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lb_bridge u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_rdata    (cpu_rdata),
        .cpu_rdy_n    (cpu_rdy_n),
        .cpu_size32_n (cpu_size32_n),
        .lb_clk       (lb_clk),
        .lb_ads_n     (lb_ads_n),
        .lb_wr        (lb_wr),
        .lb_addr      (lb_addr),
        .lb_wdata     (lb_wdata),
        .lb_wdata_oe  (lb_wdata_oe),
        .lb_rdata     (lb_rdata),
        .lb_rdy_n     (lb_rdy_n)
    );

    // slave acts just after each local rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            slv_active = 0;
            lb_rdy_n   = 1'b1;
            lb_rdata   = 32'hDEAD_BEEF;
        end else if (lb_clk) begin
            lb_rdy_n = 1'b1;
            lb_rdata = 32'hDEAD_BEEF;
            if (!lb_ads_n) begin
                slv_active = 1;
                slv_cnt    = slv_waits;
            end else if (slv_active) begin
                if (slv_cnt == 0) begin
                    lb_rdy_n   = 1'b0;
                    lb_rdata   = slv_data;
                    slv_active = 0;
                end else begin
                    slv_cnt = slv_cnt - 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic t_reset();
        logic prev;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(cpu_rdy_n == 1'b1, "R1 cpu_rdy_n", 32'(cpu_rdy_n), 1);
        chk(cpu_size32_n == 1'b1, "R1 cpu_size32_n", 32'(cpu_size32_n), 1);
        chk(lb_ads_n == 1'b1, "R1 lb_ads_n", 32'(lb_ads_n), 1);
        chk(lb_wdata_oe == 1'b0, "R1 lb_wdata_oe", 32'(lb_wdata_oe), 0);
        chk(lb_clk == 1'b0, "R1 lb_clk", 32'(lb_clk), 0);
        rst_n = 1'b1;
        prev = lb_clk;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(lb_clk != prev, "R2 lb_clk toggle", 32'(lb_clk), 32'(~prev));
            prev = lb_clk;
        end
    endtask

    // one transaction; optional mid-flight request with another address
    task automatic t_txn(input bit we, input logic [AW-1:0] addr,
                         input logic [DW-1:0] data, input int waits,
                         input int skew, input bit inject);
        int n = 0;
        int ads_cnt = 0;
        int ads_falls = 0;
        int end_idx = -1;
        int rdy_idx = -1;
        logic prev_ads = 1'b1;
        repeat (skew) @(negedge clk);
        slv_waits = waits;
        slv_data  = data;
        cpu_we    = we;
        cpu_addr  = addr;
        cpu_wdata = we ? data : 32'h0;
        cpu_req   = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        while (n < 200) begin
            @(negedge clk);
            n++;
            if (inject && n == 3) begin
                cpu_req   = 1'b1;
                cpu_we    = ~we;
                cpu_addr  = ~addr;
                cpu_wdata = 32'h5A5A_5A5A;
            end
            if (inject && n == 4) cpu_req = 1'b0;
            chk(lb_addr == addr, "R9 lb_addr held", lb_addr, addr);
            chk(lb_wr == we, "R9 lb_wr held", 32'(lb_wr), 32'(we));
            if (!lb_ads_n) begin
                if (prev_ads) begin
                    ads_falls++;
                    chk(lb_clk == 1'b1, "R3 strobe on local rise", 32'(lb_clk), 1);
                end
                ads_cnt++;
                if (we) begin
                    chk(lb_wdata_oe == 1'b1, "R5 oe during strobe", 32'(lb_wdata_oe), 1);
                    chk(lb_wdata == data, "R5 write data", lb_wdata, data);
                end
            end
            if (!we)
                chk(lb_wdata_oe == 1'b0, "R5 oe low on read", 32'(lb_wdata_oe), 0);
            if (ads_cnt > 0 && lb_ads_n && end_idx < 0) end_idx = n;
            prev_ads = lb_ads_n;
            if (!cpu_rdy_n) begin
                rdy_idx = n;
                break;
            end
            chk(cpu_size32_n == 1'b1, "R8 size only with ready",
                32'(cpu_size32_n), 1);
        end
        chk(rdy_idx > 0, "R6 ready returned", 32'(rdy_idx), 1);
        chk(ads_cnt == 4, "R4 strobe width", 32'(ads_cnt), 4);
        chk(rdy_idx - end_idx == 2 * waits + 2, "R6 ready timing",
            32'(rdy_idx - end_idx), 32'(2 * waits + 2));
        chk(cpu_size32_n == 1'b0, "R8 size with ready", 32'(cpu_size32_n), 0);
        chk(lb_wdata_oe == 1'b0, "R5 oe released", 32'(lb_wdata_oe), 0);
        if (!we) chk(cpu_rdata == data, "R7 read data", cpu_rdata, data);
        @(negedge clk);
        chk(cpu_rdy_n == 1'b1, "R8 ready one cycle", 32'(cpu_rdy_n), 1);
        chk(cpu_size32_n == 1'b1, "R8 size one cycle", 32'(cpu_size32_n), 1);
        if (inject) begin
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!lb_ads_n && prev_ads) ads_falls++;
                prev_ads = lb_ads_n;
                chk(lb_addr == addr, "R10 addr untouched", lb_addr, addr);
            end
        end
        chk(ads_falls == 1, "R10 single strobe", 32'(ads_falls), 1);
    endtask

    initial begin
        t_reset();
        t_txn(1'b1, 32'h0000_1000, 32'hCAFE_0001, 0, 0, 1'b0);
        t_txn(1'b0, 32'h0000_2004, 32'h1234_5678, 0, 1, 1'b0);
        t_txn(1'b0, 32'h0300_0008, 32'hA5A5_0F0F, 3, 2, 1'b0);
        t_txn(1'b1, 32'h0123_4560, 32'h0BAD_F00D, 1, 3, 1'b1);
        t_txn(1'b0, 32'h03FF_FFFC, 32'h8000_0001, 2, 0, 1'b1);
        t_txn(1'b1, 32'h0000_0040, 32'hFFFF_0000, 0, 0, 1'b0);
        t_txn(1'b0, 32'h0000_0044, 32'h0000_FFFF, 1, 0, 1'b0);
        finish_run();
    end

endmodule